// File: doc/BRIEF.md
# Privileged Fence and Wait-for-Interrupt Legality Checker

This block sits beside a processor's system-instruction decoder and settles what happens when one of four privileged instructions issues. The four are wait-for-interrupt, the supervisor address-translation fence, the virtual-machine fence and the guest-physical fence. It looks at the current privilege level, whether the hart runs virtualized, which privilege extensions are present, and four trap-control status bits. From these it produces exactly one outcome: an illegal-instruction trap, a virtual-instruction fault, a one-cycle translation-cache flush pulse, or entry into a halted wait.

Each rule is an ordered chain of conditions. The illegal-instruction conditions are tested before the virtual-instruction conditions. A hart that enters the wait stays halted until any bit of its pending-and-enabled interrupt vector is set. This holds even when global interrupt enables are off. On leaving the wait it raises a one-cycle resume pulse. Requests that arrive while halted are dropped. All results are registered, so each outcome appears on the cycle after the request is sampled.

Top module: `priv_fence_check`

## Requirements
- R1: While `rst` is high at a clock edge, all result pulses, `halted` and `resume` are low after that edge.
- R2: Wait-for-interrupt (`req_op` = 0) is illegal in two cases. The first is when `tw_bit` is set and privilege is supervisor, or user on a hart without the supervisor extension. The second is in user mode on a hart with the supervisor extension while `virt_on` is low. Privilege codes are 0 user, 1 supervisor and 3 machine, and code 2 is treated as user.
- R3: Wait-for-interrupt that is not illegal raises a virtual-instruction fault when `virt_on` is high and privilege is user, or supervisor with `vtw_bit` set.
- R4: Any other wait-for-interrupt pulses `out_halt` and sets `halted` on the cycle after the request.
- R5: The supervisor fence (`req_op` = 1) is illegal below supervisor, or in supervisor with `tvm_bit` set. Otherwise it faults as a virtual instruction when `has_h_ext`, `virt_on` and `vtvm_bit` are all set. In every remaining case it pulses `out_flush`.
- R6: The virtual-machine fence (`req_op` = 2) faults as a virtual instruction in virtualized supervisor mode. It flushes in machine mode or non-virtualized supervisor mode, and is illegal otherwise.
- R7: The guest-physical fence (`req_op` = 3) is illegal in non-virtualized supervisor mode with `tvm_bit` set. Otherwise it follows R6.
- R8: Each accepted request yields exactly one result pulse, one cycle long, on the next cycle. No pulse appears without a request, and an illegal condition wins over a virtual-instruction condition.
- R9: While halted, any nonzero `irq_pend_en` clears `halted` and pulses `resume` for one cycle on the next edge.
- R10: A request that arrives while `halted` is high yields no result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction request strobe |
| req_op | input | 2 | 0 wait, 1 supervisor fence, 2 virtual-machine fence, 3 guest-physical fence |
| cur_priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Hart runs virtualized |
| has_s_ext | input | 1 | Supervisor extension present |
| has_h_ext | input | 1 | Hypervisor extension present |
| tw_bit | input | 1 | Timeout-wait trap control |
| tvm_bit | input | 1 | Trap-virtual-memory control |
| vtw_bit | input | 1 | Virtualized timeout-wait control |
| vtvm_bit | input | 1 | Virtualized trap-virtual-memory control |
| irq_pend_en | input | IRQ_W | Pending-and-enabled interrupt lines |
| out_illegal | output | 1 | Illegal-instruction result pulse |
| out_vfault | output | 1 | Virtual-instruction fault result pulse |
| out_flush | output | 1 | Translation-cache flush pulse |
| out_halt | output | 1 | Wait entry pulse |
| halted | output | 1 | Hart is in the wait state |
| resume | output | 1 | One-cycle pulse on leaving the wait |

## Verification
A rule chain checked in the wrong order shows up as the wrong result pulse one cycle after the request. A priority swap surfaces as a fault pulse where an illegal trap was expected. A wait state that sticks or leaks is visible on `halted` at once. After that, every later request shows it as well, because the request is either dropped or answered when it should not be. The wake path is judged by `resume` and `halted` one edge after a nonzero interrupt vector.

// File: rtl/priv_fence_pkg.sv
package priv_fence_pkg;

    typedef enum logic [1:0] {
        OP_WFI    = 2'd0,
        OP_SFENCE = 2'd1,
        OP_VFENCE = 2'd2,
        OP_GFENCE = 2'd3
    } sysop_e;

    typedef enum logic [1:0] {
        PL_USER  = 2'd0,
        PL_SUPER = 2'd1,
        PL_RSVD  = 2'd2,
        PL_MACH  = 2'd3
    } plevel_e;

    typedef enum logic [2:0] {
        OUT_NONE,
        OUT_ILLEGAL,
        OUT_VFAULT,
        OUT_FLUSH,
        OUT_HALT
    } outcome_e;

    typedef struct packed {
        plevel_e priv;
        logic    virt;
        logic    has_s;
        logic    has_h;
        logic    tw;
        logic    tvm;
        logic    vtw;
        logic    vtvm;
    } ctx_t;

    typedef struct packed {
        logic illegal;
        logic vfault;
        logic flush;
        logic halt;
    } pulse_t;

    function automatic logic is_user(plevel_e p);
        return (p == PL_USER) || (p == PL_RSVD);
    endfunction

    function automatic pulse_t to_pulse(outcome_e o);
        pulse_t p;
        p.illegal = (o == OUT_ILLEGAL);
        p.vfault  = (o == OUT_VFAULT);
        p.flush   = (o == OUT_FLUSH);
        p.halt    = (o == OUT_HALT);
        return p;
    endfunction

endpackage

// File: rtl/pf_wfi_rule.sv
module pf_wfi_rule
    import priv_fence_pkg::*;
(
    input  ctx_t     ctx,
    output outcome_e verdict
);
    logic u_mode, s_mode, tw_trap, nos_trap;

    assign u_mode   = is_user(ctx.priv);
    assign s_mode   = (ctx.priv == PL_SUPER);
    assign tw_trap  = (s_mode || (!ctx.has_s && u_mode)) && ctx.tw;
    assign nos_trap = ctx.has_s && u_mode && !ctx.virt;

    always_comb begin
        if (tw_trap || nos_trap)
            verdict = OUT_ILLEGAL;
        else if (ctx.virt && (u_mode || (s_mode && ctx.vtw)))
            verdict = OUT_VFAULT;
        else
            verdict = OUT_HALT;
    end
endmodule

// File: rtl/pf_fence_rule.sv
module pf_fence_rule
    import priv_fence_pkg::*;
#(
    parameter sysop_e KIND = OP_SFENCE
) (
    input  ctx_t     ctx,
    output outcome_e verdict
);
    logic at_s, at_m;

    assign at_s = (ctx.priv == PL_SUPER);
    assign at_m = (ctx.priv == PL_MACH);

    generate
        if (KIND == OP_SFENCE) begin : g_sup
            always_comb begin
                if (!(at_s || at_m) || (at_s && ctx.tvm))
                    verdict = OUT_ILLEGAL;
                else if (ctx.has_h && ctx.virt && ctx.vtvm)
                    verdict = OUT_VFAULT;
                else
                    verdict = OUT_FLUSH;
            end
        end else begin : g_hyp
            logic pre_trap;
            assign pre_trap = (KIND == OP_GFENCE) && at_s && !ctx.virt && ctx.tvm;
            always_comb begin
                if (pre_trap)
                    verdict = OUT_ILLEGAL;
                else if (at_s && ctx.virt)
                    verdict = OUT_VFAULT;
                else if (at_m || at_s)
                    verdict = OUT_FLUSH;
                else
                    verdict = OUT_ILLEGAL;
            end
        end
    endgenerate
endmodule

// File: rtl/pf_wait_ctl.sv
module pf_wait_ctl #(
    parameter int IRQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    input  logic [IRQ_W-1:0] irq_vec,
    output logic             halted,
    output logic             resume
);
    logic wake;
    assign wake = |irq_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            halted <= 1'b0;
            resume <= 1'b0;
        end else begin
            resume <= halted && wake;
            if (halted) begin
                if (wake) halted <= 1'b0;
            end else if (enter) begin
                halted <= 1'b1;
            end
        end
    end

    a_r9_wake_exits: assert property (@(posedge clk) disable iff (rst)
        (halted && wake) |=> (!halted && resume));

    a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (halted && !wake) |=> (halted && !resume));

    a_r4_entry_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> $past(enter));
endmodule

// File: rtl/priv_fence_check.sv
module priv_fence_check
    import priv_fence_pkg::*;
#(
    parameter int IRQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [1:0]       cur_priv,
    input  logic             virt_on,
    input  logic             has_s_ext,
    input  logic             has_h_ext,
    input  logic             tw_bit,
    input  logic             tvm_bit,
    input  logic             vtw_bit,
    input  logic             vtvm_bit,
    input  logic [IRQ_W-1:0] irq_pend_en,
    output logic             out_illegal,
    output logic             out_vfault,
    output logic             out_flush,
    output logic             out_halt,
    output logic             halted,
    output logic             resume
);
    localparam int NUM_OPS = 4;

    ctx_t     ctx;
    outcome_e rule_v [NUM_OPS];
    outcome_e chosen;
    outcome_e verdict;
    logic     accept;
    pulse_t   pulse_q;

    assign ctx.priv  = plevel_e'(cur_priv);
    assign ctx.virt  = virt_on;
    assign ctx.has_s = has_s_ext;
    assign ctx.has_h = has_h_ext;
    assign ctx.tw    = tw_bit;
    assign ctx.tvm   = tvm_bit;
    assign ctx.vtw   = vtw_bit;
    assign ctx.vtvm  = vtvm_bit;

    pf_wfi_rule u_wfi (
        .ctx     (ctx),
        .verdict (rule_v[0])
    );

    generate
        for (genvar k = 1; k < NUM_OPS; k++) begin : g_fence
            pf_fence_rule #(.KIND(sysop_e'(k))) u_rule (
                .ctx     (ctx),
                .verdict (rule_v[k])
            );
        end
    endgenerate

    assign accept  = req_valid && !halted;
    assign chosen  = rule_v[req_op];
    assign verdict = accept ? chosen : OUT_NONE;

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= '0;
        else     pulse_q <= to_pulse(verdict);
    end

    pf_wait_ctl #(.IRQ_W(IRQ_W)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .enter   (verdict == OUT_HALT),
        .irq_vec (irq_pend_en),
        .halted  (halted),
        .resume  (resume)
    );

    assign out_illegal = pulse_q.illegal;
    assign out_vfault  = pulse_q.vfault;
    assign out_flush   = pulse_q.flush;
    assign out_halt    = pulse_q.halt;

    a_r8_single_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_illegal, out_vfault, out_flush, out_halt}));

    a_r8_result_needs_req: assert property (@(posedge clk) disable iff (rst)
        (out_illegal || out_vfault || out_flush || out_halt)
            |-> ($past(req_valid) && !$past(halted)));

    a_r6_user_vm_fence: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !halted && req_op == 2'd2 && cur_priv == 2'd0) |=> out_illegal);

    a_r4_machine_wait: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !halted && req_op == 2'd0 && cur_priv == 2'd3) |=> (out_halt && halted));

    a_r10_drop_when_halted: assert property (@(posedge clk) disable iff (rst)
        (req_valid && halted) |=> !(out_illegal || out_vfault || out_flush || out_halt));
endmodule

// File: tb/priv_fence_check_test.sv
module priv_fence_check_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_op, cur_priv;
    logic        virt_on, has_s_ext, has_h_ext, tw_bit, tvm_bit, vtw_bit, vtvm_bit;
    logic [15:0] irq_pend_en;
    logic        out_illegal, out_vfault, out_flush, out_halt, halted, resume;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  m_halted = 1'b0;

    always #10 clk = ~clk;

    priv_fence_check #(.IRQ_W(16)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .cur_priv(cur_priv), .virt_on(virt_on), .has_s_ext(has_s_ext),
        .has_h_ext(has_h_ext), .tw_bit(tw_bit), .tvm_bit(tvm_bit),
        .vtw_bit(vtw_bit), .vtvm_bit(vtvm_bit), .irq_pend_en(irq_pend_en),
        .out_illegal(out_illegal), .out_vfault(out_vfault), .out_flush(out_flush),
        .out_halt(out_halt), .halted(halted), .resume(resume)
    );

    // 0 none, 1 illegal, 2 virtual fault, 3 flush, 4 halt
    function automatic int ref_outcome(bit [1:0] op, bit [1:0] pr, bit vi, bit hs,
                                       bit hh, bit tw, bit tvm, bit vtw, bit vtvm);
        bit u = (pr == 2'd0) || (pr == 2'd2);
        bit s = (pr == 2'd1);
        bit m = (pr == 2'd3);
        case (op)
            2'd0: begin
                if (((s || (!hs && u)) && tw) || (hs && u && !vi)) return 1;
                if (vi && (u || (s && vtw))) return 2;
                return 4;
            end
            2'd1: begin
                if (u || (s && tvm)) return 1;
                if (hh && vi && vtvm) return 2;
                return 3;
            end
            default: begin
                if (op == 2'd3 && s && !vi && tvm) return 1;
                if (s && vi) return 2;
                if (m || s) return 3;
                return 1;
            end
        endcase
    endfunction

    task automatic compare(string tag, bit [5:0] got, bit [5:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {ill,vf,fl,ht,halted,resume} got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic apply(bit v, bit [1:0] op, bit [1:0] pr, bit vi, bit hs, bit hh,
                         bit tw, bit tvm, bit vtw, bit vtvm, bit [15:0] irq);
        int       o;
        bit [5:0] exp;
        string    tag;
        req_valid = v; req_op = op; cur_priv = pr; virt_on = vi;
        has_s_ext = hs; has_h_ext = hh; tw_bit = tw; tvm_bit = tvm;
        vtw_bit = vtw; vtvm_bit = vtvm; irq_pend_en = irq;
        exp = '0;
        if (m_halted) begin
            tag = v ? "R10" : "R9";
            if (irq != 0) begin
                exp[0] = 1'b1;
                m_halted = 1'b0;
                tag = "R9";
            end else begin
                exp[1] = 1'b1;
            end
        end else if (v) begin
            o = ref_outcome(op, pr, vi, hs, hh, tw, tvm, vtw, vtvm);
            case (o)
                1: exp[5] = 1'b1;
                2: exp[4] = 1'b1;
                3: exp[3] = 1'b1;
                default: begin exp[2] = 1'b1; exp[1] = 1'b1; m_halted = 1'b1; end
            endcase
            case (op)
                2'd0: tag = (o == 1) ? "R2" : (o == 2) ? "R3" : "R4";
                2'd1: tag = "R5";
                2'd2: tag = "R6";
                default: tag = "R7";
            endcase
        end else begin
            tag = "R8";
        end
        @(negedge clk);
        compare(tag, {out_illegal, out_vfault, out_flush, out_halt, halted, resume}, exp);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b1; req_op = 2'd0; cur_priv = 2'd3;
        virt_on = 0; has_s_ext = 1; has_h_ext = 1; tw_bit = 0; tvm_bit = 0;
        vtw_bit = 0; vtvm_bit = 0; irq_pend_en = '0;
        repeat (3) @(negedge clk);
        compare("R1", {out_illegal, out_vfault, out_flush, out_halt, halted, resume}, 6'b0);
        rst = 1'b0;

        // R4 machine wait, R10 dropped request, R9 wake
        apply(1, 2'd0, 2'd3, 0, 1, 1, 1, 0, 1, 0, 16'h0);
        apply(1, 2'd1, 2'd3, 0, 1, 1, 0, 0, 0, 0, 16'h0);
        apply(1, 2'd0, 2'd1, 0, 1, 1, 1, 0, 0, 0, 16'h8000);
        apply(0, 2'd0, 2'd3, 0, 1, 1, 0, 0, 0, 0, 16'h0);
        // R2 wait traps
        apply(1, 2'd0, 2'd1, 0, 1, 1, 1, 0, 0, 0, 16'h0);
        apply(1, 2'd0, 2'd0, 0, 1, 1, 0, 0, 0, 0, 16'h0);
        // R8 priority: illegal beats virtual fault
        apply(1, 2'd0, 2'd1, 1, 1, 1, 1, 0, 1, 0, 16'h0);
        // R3 virtual fault
        apply(1, 2'd0, 2'd1, 1, 1, 1, 0, 0, 1, 0, 16'h0);
        // user on hart without supervisor: halts, then R9 wake on bit 0
        apply(1, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 16'h0);
        apply(0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 16'h0001);
        // R5
        apply(1, 2'd1, 2'd0, 0, 1, 1, 0, 0, 0, 0, 16'h0);
        apply(1, 2'd1, 2'd1, 0, 1, 1, 0, 1, 0, 0, 16'h0);
        apply(1, 2'd1, 2'd1, 1, 1, 1, 0, 0, 0, 1, 16'h0);
        apply(1, 2'd1, 2'd3, 0, 1, 1, 0, 1, 0, 0, 16'h0);
        // R6
        apply(1, 2'd2, 2'd1, 1, 1, 1, 0, 0, 0, 0, 16'h0);
        apply(1, 2'd2, 2'd3, 1, 1, 1, 0, 0, 0, 0, 16'h0);
        apply(1, 2'd2, 2'd0, 0, 1, 1, 0, 0, 0, 0, 16'h0);
        // R7
        apply(1, 2'd3, 2'd1, 0, 1, 1, 0, 1, 0, 0, 16'h0);
        apply(1, 2'd3, 2'd1, 1, 1, 1, 0, 1, 0, 0, 16'h0);
        apply(1, 2'd3, 2'd1, 0, 1, 1, 0, 0, 0, 0, 16'h0);
        // R8 idle
        apply(0, 2'd1, 2'd3, 0, 1, 1, 0, 0, 0, 0, 16'h0);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            bit [15:0] irq;
            irq = ($urandom % 4 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
            apply(($urandom % 5) != 0, 2'($urandom), 2'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), irq);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule